// File: doc/BRIEF.md
# Word-to-Byte Serial FIFO Port

This block sits between a 32-bit register interface and the byte-serial datapath of a serial host controller. Software stores a whole word into the transmit side with one write strobe. The word is split into four bytes, and the least significant byte enters the queue first. On the receive side, one read strobe collects up to four bytes from the receive queue into a word. The first byte popped lands in the lowest byte lane.

The serial engine drains transmit bytes and delivers receive bytes through plain valid/ready byte handshakes. The block keeps the flags software needs to manage both queues:
- empty and full for each queue;
- a fill level for each queue, counted in 32-bit words with partial words rounded up;
- two sticky error bits.

The overflow error is set when a word does not fit in the transmit queue. In that case the bytes that fit are kept and the rest are dropped. The underflow error is set when a read finds fewer than four bytes waiting. That read still returns the bytes that were present, and the unused upper lanes read as zero.

Top module: `wbf_port`

## Requirements
- R1: After reset both queues are empty: `tx_empty_o` and `rx_empty_o` are 1, both full flags are 0, both word levels are 0, both error bits are 0, `tx_valid_o` is 0 and `rx_ready_o` is 1.
- R2: A pulse on `tx_wr_i` queues the four bytes of `tx_wdata_i` in the order bits 7:0, 15:8, 23:16, 31:24, and the engine receives them in that order.
- R3: When a word write finds fewer than four free transmit bytes (judged on the level before that cycle), only the first free-count bytes are queued and the rest are dropped; `tx_full_o` becomes 1 and `err_overflow_o` becomes 1 on the following cycle.
- R4: A pulse on `rx_rd_i` pops up to four bytes; the k-th byte popped (k = 0..3) is placed in bits 8k+7:8k of `rx_rdata_o`, which holds the result from the cycle after the strobe.
- R5: When a read finds fewer than four bytes, the bytes present are returned with the missing upper lanes zero, `rx_empty_o` becomes 1 and `err_underflow_o` becomes 1.
- R6: On the cycle after any read strobe, `rx_full_o` is 0.
- R7: A word write clears `tx_empty_o`, and `tx_level_o` equals the transmit byte count divided by four, rounded up.
- R8: `rx_level_o` equals the receive byte count divided by four, rounded up.
- R9: Both error bits are sticky: once set, they stay 1 through later error-free accesses until reset.
- R10: A transmit byte leaves only on a cycle with `tx_valid_o` and `tx_ready_i` both high. `rx_ready_o` is 0 while the receive queue is full, and a byte offered then is not stored.
- R11: A word write and an engine pop in the same cycle both take effect. Likewise, a read and an engine push in the same cycle both take effect. The read sees only the bytes stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr_i | input | 1 | Transmit word write strobe |
| tx_wdata_i | input | 32 | Transmit word |
| rx_rd_i | input | 1 | Receive word read strobe |
| rx_rdata_o | output | 32 | Assembled receive word, valid the cycle after the strobe |
| tx_byte_o | output | 8 | Transmit byte at the head of the queue |
| tx_valid_o | output | 1 | Transmit queue not empty |
| tx_ready_i | input | 1 | Engine takes the head byte |
| rx_byte_i | input | 8 | Received byte from the engine |
| rx_valid_i | input | 1 | Engine offers a received byte |
| rx_ready_o | output | 1 | Receive queue has room |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| tx_level_o | output | 8 | Transmit fill level in words, rounded up |
| rx_level_o | output | 8 | Receive fill level in words, rounded up |
| err_overflow_o | output | 1 | Sticky transmit overflow error |
| err_underflow_o | output | 1 | Sticky receive underflow error |

## Verification
Two collisions can happen in a single cycle:
- a software word write while the engine takes the head transmit byte;
- a software word read while the engine delivers a receive byte.

The bench provokes each collision by raising both strobes on the same clock edge. For the transmit collision, it judges the result by the exact byte sequence drained afterwards and by the word level. For the receive collision, it checks that the read returns only the earlier bytes with an underflow and that the newly delivered byte is still retrievable by the next read.

// File: rtl/wbf_pkg.sv
// Shared constants and helpers for the word-to-byte FIFO port.
// Assumes a 32-bit word made of four 8-bit lanes.
package wbf_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int LCNT_W = $clog2(LANES + 1);

    // Bytes to words, rounding a partial word up.
    function automatic int unsigned ceil_words(input int unsigned nbytes);
        return (nbytes + LANES - 1) / LANES;
    endfunction
endpackage

// File: rtl/wbf_byte_fifo.sv
// Byte FIFO that accepts up to LANES bytes and releases up to LANES bytes
// per cycle. Lane 0 of a push is stored first; peek lane k shows the byte
// k places behind the head. Assumes DEPTH is a power of two and that the
// caller never pushes beyond free space nor pops beyond the level.
module wbf_byte_fifo #(
    parameter int DEPTH = 256,
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(LANES+1)-1:0] push_n,
    input  logic [LANES*8-1:0]         push_data,
    input  logic [$clog2(LANES+1)-1:0] pop_n,
    output logic [LANES*8-1:0]         peek_data,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;

    // Store the accepted lanes at consecutive write addresses.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(push_n)) mem[wptr + AW'(i)] <= push_data[i*8 +: 8];
        end
    end

    // Advance pointers and the byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            wptr <= wptr + AW'(push_n);
            rptr <= rptr + AW'(pop_n);
            cnt  <= cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    // Expose the next LANES bytes from the head.
    for (genvar g = 0; g < LANES; g++) begin : g_peek
        assign peek_data[g*8 +: 8] = mem[rptr + AW'(g)];
    end

    assign level = cnt;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(push_n) <= DEPTH - int'(cnt));
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n <= LCNT'(0) + pop_n && int'(pop_n) <= int'(cnt));
    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= DEPTH);

    localparam int LCNT = $clog2(LANES + 1);
endmodule

// File: rtl/wbf_sticky_flags.sv
// Set-only error flags: each bit rises on its event and stays high
// until synchronous reset. Assumes events are single-cycle or level.
module wbf_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] flag_o
);
    // Accumulate events into the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= flag_o | set_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            flag_o[g] |=> flag_o[g]);
    end
endmodule

// File: rtl/wbf_port.sv
// Word-to-byte FIFO port: splits 32-bit transmit writes into bytes
// (least significant first) and packs receive bytes into 32-bit reads.
// Assumes single-cycle strobes and queue depths of at least four bytes.
// Free space and fill are judged on the level held before each cycle.
module wbf_port #(
    parameter int TX_DEPTH = 256,
    parameter int RX_DEPTH = 256,
    parameter int LEVEL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_wr_i,
    input  logic [31:0]        tx_wdata_i,
    input  logic               rx_rd_i,
    output logic [31:0]        rx_rdata_o,
    output logic [7:0]         tx_byte_o,
    output logic               tx_valid_o,
    input  logic               tx_ready_i,
    input  logic [7:0]         rx_byte_i,
    input  logic               rx_valid_i,
    output logic               rx_ready_o,
    output logic               tx_empty_o,
    output logic               tx_full_o,
    output logic               rx_empty_o,
    output logic               rx_full_o,
    output logic [LEVEL_W-1:0] tx_level_o,
    output logic [LEVEL_W-1:0] rx_level_o,
    output logic               err_overflow_o,
    output logic               err_underflow_o
);
    import wbf_pkg::*;

    localparam int TX_CW = $clog2(TX_DEPTH) + 1;
    localparam int RX_CW = $clog2(RX_DEPTH) + 1;

    logic [TX_CW-1:0]  tx_lvl;
    logic [RX_CW-1:0]  rx_lvl;
    logic [LCNT_W-1:0] tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [WORD_W-1:0] tx_peek, rx_peek, rx_wide;
    logic              tx_pop, rx_push, ovf_evt, udf_evt;
    int                tx_free;
    logic [1:0]        errs;

    // Transmit side: clip the word to the free space, pop one byte per handshake.
    always_comb begin
        tx_free   = TX_DEPTH - int'(tx_lvl);
        ovf_evt   = tx_wr_i && (tx_free < LANES);
        tx_push_n = '0;
        if (tx_wr_i) tx_push_n = ovf_evt ? LCNT_W'(tx_free) : LCNT_W'(LANES);
        tx_pop    = tx_valid_o && tx_ready_i;
        tx_pop_n  = LCNT_W'(tx_pop);
    end

    // Receive side: push one byte per handshake, pop what a read can take.
    always_comb begin
        rx_push   = rx_valid_i && rx_ready_o;
        rx_push_n = LCNT_W'(rx_push);
        udf_evt   = rx_rd_i && (int'(rx_lvl) < LANES);
        rx_pop_n  = '0;
        if (rx_rd_i) rx_pop_n = udf_evt ? LCNT_W'(rx_lvl) : LCNT_W'(LANES);
        rx_wide   = {{(WORD_W-BYTE_W){1'b0}}, rx_byte_i};
    end

    wbf_byte_fifo #(.DEPTH(TX_DEPTH), .LANES(LANES)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .push_data(tx_wdata_i),
        .pop_n(tx_pop_n), .peek_data(tx_peek), .level(tx_lvl)
    );

    wbf_byte_fifo #(.DEPTH(RX_DEPTH), .LANES(LANES)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_push_n), .push_data(rx_wide),
        .pop_n(rx_pop_n), .peek_data(rx_peek), .level(rx_lvl)
    );

    wbf_sticky_flags #(.N(2)) u_err (
        .clk(clk), .rst_n(rst_n),
        .set_i({udf_evt, ovf_evt}), .flag_o(errs)
    );

    // Capture the assembled read word; lanes without a byte read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rdata_o <= '0;
        end else if (rx_rd_i) begin
            for (int i = 0; i < LANES; i++)
                rx_rdata_o[i*8 +: 8] <= (i < int'(rx_lvl)) ? rx_peek[i*8 +: 8] : 8'h00;
        end
    end

    assign tx_byte_o       = tx_peek[7:0];
    assign tx_valid_o      = (tx_lvl != '0);
    assign rx_ready_o      = (int'(rx_lvl) != RX_DEPTH);
    assign tx_empty_o      = (tx_lvl == '0);
    assign tx_full_o       = (int'(tx_lvl) == TX_DEPTH);
    assign rx_empty_o      = (rx_lvl == '0);
    assign rx_full_o       = (int'(rx_lvl) == RX_DEPTH);
    assign tx_level_o      = LEVEL_W'(ceil_words(32'(tx_lvl)));
    assign rx_level_o      = LEVEL_W'(ceil_words(32'(rx_lvl)));
    assign err_overflow_o  = errs[0];
    assign err_underflow_o = errs[1];

    assert_overflow_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_i && tx_free < LANES && !tx_ready_i) |=> (err_overflow_o && tx_full_o));
    assert_underflow_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_i && int'(rx_lvl) < LANES && !rx_valid_i) |=> (err_underflow_o && rx_empty_o));
    assert_read_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd_i |=> !rx_full_o);
    assert_write_clears_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_i |=> !tx_empty_o);
    assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_empty_o && tx_full_o) && !(rx_empty_o && rx_full_o));
endmodule

// File: tb/sim_wbf_port.sv
module sim_wbf_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_wr_i, rx_rd_i, tx_ready_i, rx_valid_i;
    logic [31:0] tx_wdata_i, rx_rdata_o;
    logic [7:0]  tx_byte_o, rx_byte_i, tx_level_o, rx_level_o;
    logic        tx_valid_o, rx_ready_o, tx_empty_o, tx_full_o, rx_empty_o, rx_full_o;
    logic        err_overflow_o, err_underflow_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    wbf_port u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_wr_i(tx_wr_i), .tx_wdata_i(tx_wdata_i),
        .rx_rd_i(rx_rd_i), .rx_rdata_o(rx_rdata_o),
        .tx_byte_o(tx_byte_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .rx_byte_i(rx_byte_i), .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o),
        .tx_empty_o(tx_empty_o), .tx_full_o(tx_full_o),
        .rx_empty_o(rx_empty_o), .rx_full_o(rx_full_o),
        .tx_level_o(tx_level_o), .rx_level_o(rx_level_o),
        .err_overflow_o(err_overflow_o), .err_underflow_o(err_underflow_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; tx_wr_i = 0; rx_rd_i = 0; tx_ready_i = 0; rx_valid_i = 0;
        tx_wdata_i = '0; rx_byte_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr_word(input logic [31:0] w);
        @(negedge clk); tx_wr_i = 1; tx_wdata_i = w;
        @(negedge clk); tx_wr_i = 0;
    endtask

    task automatic rd_word(output logic [31:0] w);
        @(negedge clk); rx_rd_i = 1;
        @(negedge clk); rx_rd_i = 0; w = rx_rdata_o;
    endtask

    task automatic pop_byte(output logic [7:0] b, output logic v);
        @(negedge clk); tx_ready_i = 1; b = tx_byte_o; v = tx_valid_o;
        @(negedge clk); tx_ready_i = 0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk); rx_valid_i = 1; rx_byte_i = b;
        @(negedge clk); rx_valid_i = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 tx_empty", tx_empty_o, 1);
        chk("R1 rx_empty", rx_empty_o, 1);
        chk("R1 fulls", {tx_full_o, rx_full_o}, 0);
        chk("R1 levels", {tx_level_o, rx_level_o}, 0);
        chk("R1 errors", {err_overflow_o, err_underflow_o}, 0);
        chk("R1 handshakes", {tx_valid_o, rx_ready_o}, 2'b01);
    endtask

    task automatic t_tx_order();
        logic [7:0] b; logic v; int bad = 0;
        do_reset();
        wr_word(32'h44332211);
        chk("R7 tx_empty cleared", tx_empty_o, 0);
        chk("R7 tx_level one word", tx_level_o, 1);
        repeat (3) @(negedge clk);
        chk("R10 no pop without ready", tx_level_o, 1);
        for (int i = 0; i < 4; i++) begin
            pop_byte(b, v);
            if (!v || b !== 8'(8'h11 * (i + 1))) bad++;
        end
        chk("R2 byte order", bad, 0);
        chk("R2 drained empty", tx_empty_o, 1);
    endtask

    task automatic t_tx_pad();
        logic [7:0] b; logic v;
        do_reset();
        wr_word(32'h0);
        wr_word(32'h0);
        pop_byte(b, v);
        chk("R7 seven bytes round up", tx_level_o, 2);
    endtask

    task automatic t_rx_partial();
        logic [31:0] w;
        do_reset();
        for (int i = 1; i <= 5; i++) push_byte(8'(8'hA0 + i));
        chk("R8 rx_level five bytes", rx_level_o, 2);
        rd_word(w);
        chk("R4 assembled word", w, 32'hA4A3A2A1);
        chk("R4 no underflow", err_underflow_o, 0);
        rd_word(w);
        chk("R5 partial word", w, 32'h000000A5);
        chk("R5 underflow set", err_underflow_o, 1);
        chk("R5 rx_empty", rx_empty_o, 1);
        push_byte(8'h01); push_byte(8'h02); push_byte(8'h03); push_byte(8'h04);
        rd_word(w);
        chk("R9 underflow sticky", err_underflow_o, 1);
    endtask

    task automatic t_rx_full();
        logic [31:0] w; int bad = 0;
        do_reset();
        for (int i = 0; i < 256; i++) push_byte(8'(i));
        chk("R10 rx_full", rx_full_o, 1);
        chk("R10 rx_ready low", rx_ready_o, 0);
        push_byte(8'hEE);
        rd_word(w);
        chk("R6 read clears full", rx_full_o, 0);
        chk("R4 first word", w, 32'h03020100);
        for (int k = 1; k < 64; k++) begin
            rd_word(w);
            if (w !== {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}) bad++;
        end
        chk("R10 byte offered when full dropped", bad, 0);
        chk("R10 empty after 64 words", rx_empty_o, 1);
    endtask

    task automatic t_overflow();
        logic [7:0] b; logic v; int bad = 0;
        do_reset();
        for (int k = 0; k < 64; k++) wr_word({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
        chk("R3 exact fill no overflow", err_overflow_o, 0);
        chk("R7 level 64 words", tx_level_o, 64);
        pop_byte(b, v); pop_byte(b, v);
        wr_word(32'hCAFEF00D);
        chk("R3 overflow set", err_overflow_o, 1);
        chk("R3 tx_full", tx_full_o, 1);
        for (int j = 2; j < 256; j++) begin
            pop_byte(b, v);
            if (!v || b !== 8'(j)) bad++;
        end
        pop_byte(b, v); if (b !== 8'h0D) bad++;
        pop_byte(b, v); if (b !== 8'hF0) bad++;
        chk("R3 kept and dropped bytes", bad, 0);
        chk("R3 empty after drain", tx_empty_o, 1);
        wr_word(32'h1);
        chk("R9 overflow sticky", err_overflow_o, 1);
    endtask

    task automatic t_same_cycle();
        logic [7:0] b; logic v; logic [31:0] w; int bad = 0;
        do_reset();
        wr_word(32'h44332211);
        @(negedge clk); tx_wr_i = 1; tx_wdata_i = 32'h88776655; tx_ready_i = 1;
        chk("R11 head byte during write", tx_byte_o, 8'h11);
        @(negedge clk); tx_wr_i = 0; tx_ready_i = 0;
        chk("R11 tx level after collision", tx_level_o, 2);
        for (int i = 2; i <= 8; i++) begin
            pop_byte(b, v);
            if (!v || b !== 8'(8'h11 * i)) bad++;
        end
        chk("R11 tx sequence after collision", bad, 0);
        push_byte(8'hB1); push_byte(8'hB2);
        @(negedge clk); rx_rd_i = 1; rx_valid_i = 1; rx_byte_i = 8'hB3;
        @(negedge clk); rx_rd_i = 0; rx_valid_i = 0;
        chk("R11 read sees old bytes", rx_rdata_o, 32'h0000B2B1);
        chk("R11 underflow on short read", err_underflow_o, 1);
        chk("R11 new byte kept", rx_level_o, 1);
        rd_word(w);
        chk("R11 new byte read back", w, 32'h000000B3);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_tx_order();
        t_tx_pad();
        t_rx_partial();
        t_rx_full();
        t_overflow();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule